// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer with Serial Readout

This block is the digital control core of a small successive-approximation converter. A host starts a conversion by pulling an active-low select pin low and then supplies a serial clock. Each falling serial-clock edge performs one step of the binary search on an internal trial register, which drives a capacitive DAC. The comparator answer is returned on a single bit. The bit that has just been decided is put on the serial data output on that same edge, so the result leaves the block in the frame that sampled it, with no pipeline latency. The resolution `RES` is a parameter. A frame takes `RES + 1` falling edges: one to load the first trial and `RES` to decide the bits.

The host serial clock paces the conversion, so conversion time follows its period and there is no separate conversion clock. The select and serial-clock pins arrive as plain levels. They pass through `SYNC_STAGES` flops on the fast system clock `clk` and go through edge detection. Because the host clock is the only pacing, the serial pins carry no valid/ready handshake and the block never applies back-pressure. The host must keep each serial-clock level for more than `SYNC_STAGES + 1` system-clock cycles.

Once the last bit has been decided, the block raises its sleep flag and lets the sample/hold track again, which opens the acquisition window for the next frame. Any further serial-clock edges are ignored. The data pin keeps the last bit until select rises, and then it floats. Only a new falling select leaves sleep.

Top module: `sar_serial_seq`

## Requirements
- R1: After reset, `sleep_o`=1, `hold_o`=0 (tracking), `dout_en_o`=0, `dout_o`=0 and `trial_o`=0.
- R2: A falling edge on `sel_n_i` sets `hold_o`=1 (hold), `dout_en_o`=1 and `sleep_o`=0, clears `trial_o`, and drives `dout_o`=0 as a leading zero.
- R3: The first falling `sck_i` edge of a frame loads `trial_o` with only bit `RES-1` set and keeps `dout_o`=0.
- R4: Falling edge k (2 ≤ k ≤ RES+1) decides bit `RES-k+1`: the bit stays 1 when `cmp_i`=1 (input at or above the trial level) and becomes 0 when `cmp_i`=0, the next lower bit is set as the new trial, and the decided bit appears on `dout_o`, MSB first.
- R5: After RES+1 falling edges `trial_o` holds the result in straight binary, `sleep_o`=1 and `hold_o`=0, while `dout_en_o` stays 1 until select rises.
- R6: `dout_o` and `trial_o` change only in the cycle after a detected falling `sck_i` edge or a select edge. They stay stable while the host samples on the rising edge.
- R7: Falling `sck_i` edges after the frame is complete leave `dout_o` and `trial_o` unchanged.
- R8: While `sel_n_i` is high, `dout_en_o`=0 and `dout_o`=0 (the pad floats).
- R9: A rising select before the frame is complete aborts the conversion (`sleep_o`=1, `hold_o`=0, `dout_en_o`=0), and the next falling select starts a clean frame.
- R10: When a select edge and a falling `sck_i` edge are detected in the same cycle, the select edge wins and that serial edge is not counted.
- R11: `sleep_o` is cleared only by a detected falling select edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n_i | input | 1 | Active-low frame select from the host |
| sck_i | input | 1 | Host serial clock; falling edges step the search |
| cmp_i | input | 1 | Comparator answer: 1 when the held input is at or above the trial level |
| trial_o | output | RES | Trial code driving the DAC; holds the result after the frame |
| hold_o | output | 1 | Sample/hold control: 1 hold, 0 track |
| dout_o | output | 1 | Serial data, MSB first; 0 when the pad is not driven |
| dout_en_o | output | 1 | Output-enable for the serial data pad driver |
| sleep_o | output | 1 | Automatic power-down flag |

## Verification
A select edge and a falling serial-clock edge can be detected in the same system-clock cycle. The select edge is meant to win. The bench provokes this by changing both pins in one drive step, once at the start of a frame and once in the middle of a frame. At the start, `trial_o` must still read zero after the shared edge, and the full result must then need RES+1 further edges. In the middle of a frame, the pad must float and the trial code must keep its value from before the shared edge. After that, a fresh frame must still convert correctly.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    PH_SLEEP   = 2'd0,
    PH_CONV    = 2'd1,
    PH_HOLDOUT = 2'd2
  } phase_e;
endpackage

// File: rtl/sar_edge_sync.sv
module sar_edge_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic lvl_o,
  output logic lvl_prev_o
);
  logic [STAGES-1:0] sh;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= RST_VAL;
        else        sh <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= {STAGES{RST_VAL}};
        else        sh <= {sh[STAGES-2:0], d_i};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= sh[STAGES-1];
  end

  assign lvl_o      = sh[STAGES-1];
  assign lvl_prev_o = prev;
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int RES = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear_i,
  input  logic           load_i,
  input  logic           decide_i,
  input  logic           cmp_i,
  output logic [RES-1:0] trial_o,
  output logic [RES-1:0] ptr_o
);
  localparam logic [RES-1:0] TOP_BIT = RES'(1) << (RES - 1);

  logic [RES-1:0] trial;
  logic [RES-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial <= '0;
      ptr   <= '0;
    end else if (clear_i) begin
      trial <= '0;
      ptr   <= '0;
    end else if (load_i) begin
      trial <= TOP_BIT;
      ptr   <= TOP_BIT;
    end else if (decide_i) begin
      trial <= (trial & ~ptr) | (cmp_i ? ptr : '0) | (ptr >> 1);
      ptr   <= ptr >> 1;
    end
  end

  assign trial_o = trial;
  assign ptr_o   = ptr;
endmodule

// File: rtl/sar_frame_ctrl.sv
module sar_frame_ctrl
  import sar_seq_pkg::*;
#(
  parameter int RES = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_fall_i,
  input  logic sel_rise_i,
  input  logic sck_fall_i,
  input  logic cmp_i,
  output logic clear_o,
  output logic load_o,
  output logic decide_o,
  output logic hold_o,
  output logic dout_o,
  output logic dout_en_o,
  output logic sleep_o
);
  localparam int CW = $clog2(RES + 2);
  localparam logic [CW-1:0] LAST = CW'(RES);

  phase_e        phase;
  logic [CW-1:0] cnt;
  logic          step;

  assign step = (phase == PH_CONV) && sck_fall_i && !sel_fall_i && !sel_rise_i;

  always_comb begin
    clear_o  = sel_fall_i;
    load_o   = step && (cnt == '0);
    decide_o = step && (cnt != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_SLEEP;
      cnt       <= '0;
      hold_o    <= 1'b0;
      dout_o    <= 1'b0;
      dout_en_o <= 1'b0;
      sleep_o   <= 1'b1;
    end else if (sel_fall_i) begin
      phase     <= PH_CONV;
      cnt       <= '0;
      hold_o    <= 1'b1;
      dout_o    <= 1'b0;
      dout_en_o <= 1'b1;
      sleep_o   <= 1'b0;
    end else if (sel_rise_i) begin
      phase     <= PH_SLEEP;
      cnt       <= '0;
      hold_o    <= 1'b0;
      dout_o    <= 1'b0;
      dout_en_o <= 1'b0;
      sleep_o   <= 1'b1;
    end else if (step) begin
      cnt <= cnt + 1'b1;
      if (cnt != '0) dout_o <= cmp_i;
      if (cnt == LAST) begin
        phase   <= PH_HOLDOUT;
        hold_o  <= 1'b0;
        sleep_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq #(
  parameter int RES         = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sel_n_i,
  input  logic           sck_i,
  input  logic           cmp_i,
  output logic [RES-1:0] trial_o,
  output logic           hold_o,
  output logic           dout_o,
  output logic           dout_en_o,
  output logic           sleep_o
);
  logic sel_lvl, sel_prev, sck_lvl, sck_prev;
  logic sel_fall, sel_rise, sck_fall;
  logic clear, load, decide;
  logic [RES-1:0] ptr;

  sar_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sel_sync (
    .clk(clk), .rst_n(rst_n), .d_i(sel_n_i), .lvl_o(sel_lvl), .lvl_prev_o(sel_prev)
  );

  sar_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sck_sync (
    .clk(clk), .rst_n(rst_n), .d_i(sck_i), .lvl_o(sck_lvl), .lvl_prev_o(sck_prev)
  );

  assign sel_fall = sel_prev & ~sel_lvl;
  assign sel_rise = ~sel_prev & sel_lvl;
  assign sck_fall = sck_prev & ~sck_lvl;

  sar_frame_ctrl #(.RES(RES)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .sel_fall_i(sel_fall), .sel_rise_i(sel_rise), .sck_fall_i(sck_fall),
    .cmp_i(cmp_i),
    .clear_o(clear), .load_o(load), .decide_o(decide),
    .hold_o(hold_o), .dout_o(dout_o), .dout_en_o(dout_en_o), .sleep_o(sleep_o)
  );

  sar_trial_reg #(.RES(RES)) u_trial (
    .clk(clk), .rst_n(rst_n),
    .clear_i(clear), .load_i(load), .decide_i(decide), .cmp_i(cmp_i),
    .trial_o(trial_o), .ptr_o(ptr)
  );
endmodule

// File: rtl/sar_serial_seq_chk.sv
module sar_serial_seq_chk #(
  parameter int RES = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sel_fall,
  input logic           sel_rise,
  input logic           sck_fall,
  input logic           dout_o,
  input logic           dout_en_o,
  input logic           hold_o,
  input logic           sleep_o,
  input logic [RES-1:0] ptr,
  input logic [RES-1:0] trial_o
);
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_fall |=> (hold_o && dout_en_o && !sleep_o && !dout_o && trial_o == '0));

  p_onehot_ptr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ptr));

  p_sleep_tracks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_o |-> !hold_o);

  p_stable_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(sck_fall || sel_fall || sel_rise) |=> ($stable(dout_o) && $stable(trial_o)));

  p_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en_o |-> !dout_o);

  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_rise |=> (sleep_o && !hold_o && !dout_en_o));

  p_wake_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_o && !sel_fall) |=> sleep_o);
endmodule

bind sar_serial_seq sar_serial_seq_chk #(.RES(RES)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .sel_fall(sel_fall), .sel_rise(sel_rise), .sck_fall(sck_fall),
  .dout_o(dout_o), .dout_en_o(dout_en_o), .hold_o(hold_o), .sleep_o(sleep_o),
  .ptr(ptr), .trial_o(trial_o)
);

// File: tb/sar_serial_seq_tb.sv
module sar_serial_seq_tb;
  localparam int RES = 12;
  localparam logic [RES-1:0] TOP_BIT = RES'(1) << (RES - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1;
  logic sck = 1'b1;
  logic cmp;
  logic [RES-1:0] vin = '0;
  logic [RES-1:0] trial;
  logic hold, dout, dout_en, sleep;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  assign cmp = (vin >= trial);

  sar_serial_seq #(.RES(RES), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .sck_i(sck), .cmp_i(cmp),
    .trial_o(trial), .hold_o(hold), .dout_o(dout), .dout_en_o(dout_en), .sleep_o(sleep)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [RES-1:0] exp_code(input logic [RES-1:0] v, input int k);
    logic [RES-1:0] m;
    int idx;
    if (k == 1) return TOP_BIT;
    idx = RES - k + 1;
    m = (v >> idx) << idx;
    if (idx > 0) m = m | (RES'(1) << (idx - 1));
    return m;
  endfunction

  function automatic logic exp_bit(input logic [RES-1:0] v, input int k);
    if (k == 1) return 1'b0;
    return v[RES-k+1];
  endfunction

  task automatic start_frame(input logic [RES-1:0] v, input int half);
    vin = v;
    sel_n = 1'b0;
    wait_n(half);
    chk(hold && dout_en && !sleep && !dout && trial == '0, "R2 start",
        {trial, hold, dout_en, sleep, dout}, {RES'(0), 4'b1100});
  endtask

  task automatic step(input logic [RES-1:0] v, input int k, input int half);
    sck = 1'b0;
    wait_n(half);
    if (k == 1) chk(trial == TOP_BIT && !dout, "R3 first trial", trial, TOP_BIT);
    else begin
      chk(dout == exp_bit(v, k), "R4 bit out", dout, exp_bit(v, k));
      chk(trial == exp_code(v, k), "R4 trial", trial, exp_code(v, k));
    end
    sck = 1'b1;
    wait_n(half);
    chk(dout == exp_bit(v, k), "R6 stable at sample", dout, exp_bit(v, k));
  endtask

  task automatic end_frame(input logic [RES-1:0] v, input int half);
    chk(trial == v, "R5 result", trial, v);
    chk(sleep && !hold && dout_en, "R5 auto sleep", {sleep, hold, dout_en}, 3'b101);
    for (int e = 0; e < 2; e++) begin
      sck = 1'b0;
      wait_n(half);
      sck = 1'b1;
      wait_n(half);
      chk(trial == v && dout == v[0], "R7 extra edges ignored", {trial, dout}, {v, v[0]});
    end
    sel_n = 1'b1;
    wait_n(half);
    chk(!dout_en && !dout && sleep, "R8 float", {dout_en, dout, sleep}, 3'b001);
  endtask

  task automatic full_frame(input logic [RES-1:0] v, input int half);
    start_frame(v, half);
    for (int k = 1; k <= RES + 1; k++) step(v, k, half);
    end_frame(v, half);
  endtask

  initial begin
    void'($urandom(32'd2718));
    wait_n(3);
    rst_n = 1'b1;
    wait_n(4);
    chk(sleep && !hold && !dout_en && !dout && trial == '0, "R1 reset",
        {trial, sleep, hold, dout_en, dout}, {RES'(0), 4'b1000});

    full_frame('0, 5);
    full_frame('1, 4);
    full_frame(12'hA5A, 6);
    full_frame(12'h801, 4);
    full_frame(12'h7FF, 9);

    // R9 abort mid-frame, R10 select rise shares a cycle with a falling sck
    for (int a = 0; a < 4; a++) begin
      logic [RES-1:0] v;
      int j;
      v = RES'($urandom);
      j = 1 + int'($urandom % RES);
      start_frame(v, 5);
      for (int k = 1; k <= j; k++) step(v, k, 5);
      sel_n = 1'b1;
      sck = 1'b0;
      wait_n(5);
      chk(!dout_en && sleep && !hold, "R9 abort", {dout_en, sleep, hold}, 3'b010);
      chk(trial == exp_code(v, j), "R10 sck edge lost to select rise", trial, exp_code(v, j));
      sck = 1'b1;
      wait_n(5);
      chk(sleep, "R11 stays asleep", sleep, 1);
      full_frame(~v, 5);
    end

    // R10 select fall shares a cycle with a falling sck
    vin = 12'h3C6;
    sel_n = 1'b0;
    sck = 1'b0;
    wait_n(5);
    chk(trial == '0 && dout_en && hold, "R10 sck edge lost to select fall",
        {trial, dout_en, hold}, {RES'(0), 2'b11});
    sck = 1'b1;
    wait_n(5);
    for (int k = 1; k <= RES + 1; k++) step(12'h3C6, k, 5);
    end_frame(12'h3C6, 5);

    for (int r = 0; r < 20; r++) full_frame(RES'($urandom), 4 + int'($urandom % 6));

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule